// File: doc/BRIEF.md
# Three-Way Non-Preemptive Priority Bus Arbiter

This block decides which of three devices may drive a shared bus in each clock cycle. Each device raises its request line when it wants the bus. The arbiter answers with one grant line per device, and at most one of those lines is high at a time. Device 1 (request bit 0) has the highest priority and device 3 (request bit 2) the lowest.

A grant is a Moore output taken from the registered state. It therefore appears one cycle after the arbiter accepts a request. Once a device holds the bus, it keeps the bus for as long as it keeps requesting, even when a higher-priority device starts asking. When the holder releases its request, the arbiter spends at least one cycle with no grant before it picks the next device.

The state is a two-bit code: 00 means no grant, 01 means device 1, 10 means device 2 and 11 means device 3. An active-low asynchronous reset returns the arbiter to the no-grant state.

Top module: `bus_prio_arb`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, gnt_o is 000.
- R2: At most one bit of gnt_o is high in any cycle.
- R3: When gnt_o is 000 and req_i is non-zero at a rising edge, gnt_o after that edge has a single bit set at the lowest-numbered set bit of req_i. Bit 0 is device 1.
- R4: When gnt_o is 000 and req_i is 000 at a rising edge, gnt_o stays 000.
- R5: When the granted device's request bit is high at a rising edge, gnt_o is unchanged after that edge, whatever the other request bits are.
- R6: When the granted device's request bit is low at a rising edge, gnt_o becomes 000 after that edge, even if other request bits are high.
- R7: gnt_o never moves directly from one non-zero value to a different non-zero value. At least one 000 cycle lies between two different grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request lines. Bit 0 is device 1, the highest priority. |
| gnt_o | output | 3 | Grant lines, one-hot or zero, decoded from the state |

## Verification
The assertions check four behaviours on every cycle: that grants are exclusive, that a grant is held without preemption, that a grant ends when its holder releases the bus, and that an idle gap separates different grants. They also check the priority pick made from the idle state. Only the bench scenarios show that reset clears a grant that is in progress. The same scenarios show the exact cycle-by-cycle sequence when requests from several devices overlap, including the case where a higher-priority device arrives during a grant and is served only after the idle gap.

// File: rtl/bus_prio_arb_pkg.sv
package bus_prio_arb_pkg;
  localparam int NUM_REQ = 3;
  localparam int STATE_W = $clog2(NUM_REQ + 1);
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t ST_IDLE = '0;  // device k holds the bus in state code k
endpackage

// File: rtl/bus_prio_arb_next.sv
module bus_prio_arb_next
  import bus_prio_arb_pkg::*;
(
  input  state_t             cur_i,
  input  logic [NUM_REQ-1:0] req_i,
  output state_t             nxt_o
);
  state_t hold_idx;
  assign hold_idx = cur_i - state_t'(1);

  always_comb begin
    nxt_o = cur_i;
    if (cur_i == ST_IDLE) begin
      // scan from lowest priority so the highest set request wins
      for (int i = NUM_REQ - 1; i >= 0; i--) begin
        if (req_i[i]) nxt_o = state_t'(i + 1);
      end
    end else if (!req_i[hold_idx]) begin
      nxt_o = ST_IDLE;
    end
  end
endmodule

// File: rtl/bus_prio_arb_dec.sv
module bus_prio_arb_dec
  import bus_prio_arb_pkg::*;
(
  input  state_t             state_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
    assign gnt_o[g] = (state_i == state_t'(g + 1));
  end
endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
  import bus_prio_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  state_t state_q, state_d;

  bus_prio_arb_next u_next (.cur_i(state_q), .req_i(req_i), .nxt_o(state_d));
  bus_prio_arb_dec  u_dec  (.state_i(state_q), .gnt_o(gnt_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_grant_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_idle_pick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o == $past(req_i & (~req_i + 1'b1))));

  assert_idle_stay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

  assert_no_preempt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != '0) |=> $stable(gnt_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & req_i) == '0) |=> (gnt_o == '0));

  assert_idle_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> (gnt_o == '0 || $stable(gnt_o)));
endmodule

// File: tb/tb_bus_prio_arb.sv
module tb_bus_prio_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_i = '0;
  logic [2:0] gnt_o;
  int errors = 0;
  int checks = 0;
  logic [2:0] prev_gnt = '0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  bus_prio_arb dut (.clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o));

  // {req, expected grant after the edge}
  localparam logic [5:0] VEC [0:16] = '{
    {3'b000, 3'b000}, {3'b111, 3'b001}, {3'b111, 3'b001}, {3'b110, 3'b000},
    {3'b110, 3'b010}, {3'b011, 3'b010}, {3'b101, 3'b000}, {3'b100, 3'b100},
    {3'b111, 3'b100}, {3'b011, 3'b000}, {3'b011, 3'b001}, {3'b000, 3'b000},
    {3'b000, 3'b000}, {3'b010, 3'b010}, {3'b000, 3'b000}, {3'b100, 3'b100},
    {3'b000, 3'b000}};

  function automatic string tag_of(logic [2:0] pg, logic [2:0] eg);
    if (pg == 3'b000) return (eg != 3'b000) ? "R3" : "R4";
    return (eg == pg) ? "R5" : "R6";
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(logic [2:0] req, logic [2:0] exp, string tag);
    req_i = req;
    @(posedge clk_i);
    #1;
    check(tag, gnt_o, exp);
    check("R2", 3'($countones(gnt_o) <= 1), 3'b001);
    check("R7", 3'(prev_gnt != 0 && gnt_o != 0 && gnt_o != prev_gnt), 3'b000);
    prev_gnt = gnt_o;
  endtask

  initial begin
    #20;
    check("R1", gnt_o, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1", gnt_o, 3'b000);
    for (int i = 0; i < 17; i++) begin
      step(VEC[i][5:3], VEC[i][2:0], tag_of(prev_gnt, VEC[i][2:0]));
    end
    // R1: reset in the middle of a grant clears it at once
    step(3'b010, 3'b010, "R3");
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1", gnt_o, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_gnt = '0;
    // R5: a higher-priority request arriving during a grant does not take over
    step(3'b100, 3'b100, "R3");
    step(3'b101, 3'b100, "R5");
    step(3'b001, 3'b000, "R6");
    step(3'b001, 3'b001, "R3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: timeout reached, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule